// File: doc/BRIEF.md
# I2C Multi-Master Arbitrating Transmitter

This block is an I2C master engine that shares its bus with other masters. It drives SCL and SDA through open-drain style pull-down enables and reads the resolved line levels back through two-flop synchronizers. It issues Start, Repeated Start, Stop and Acknowledge conditions and shifts out address or data bytes. During the ninth clock of each byte it releases SDA and records the acknowledge that the receiver returns.

A bus watcher follows every Start and Stop on the wire, including those made by other masters. It keeps two status bits, start-seen and stop-seen, and the engine opens a transfer only while the bus counts as free. Whenever the engine releases SDA during a phase that it owns, it compares the line with the released level while SCL is high. If another device holds the line low, the engine abandons the condition or byte in progress, lets go of both lines, clears every pending command and the buffer-full flag, and raises a sticky collision flag.

Each bit and each condition lasts four quarter periods of `DIV` clocks. The engine holds SCL low between operations.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset both lines are released (scl_oe = sda_oe = 0). bus_collision, irq, buf_full, busy, rx_nack-independent start_seen and stop_seen all read 0, and cmd_pending reads 0.
- R2: A falling SDA while SCL is high sets start_seen and clears stop_seen. A rising SDA while SCL is high sets stop_seen and clears start_seen. Dropping enable clears both bits.
- R3: A pending Start (cmd_pending bit 0) begins only when stop_seen is 1 or when both status bits are 0. While another master's Start keeps the bus busy, the command stays pending and SDA is not driven.
- R4: A buffered byte is sent most significant bit first. SDA is held constant while SCL is high. On the ninth clock SDA is released and the sampled level goes to rx_nack (1 means not acknowledged). At the end of the byte, buf_full clears and irq is set.
- R5: A write (wr_valid) while buf_full is 1 is ignored, and the byte already buffered is the one that is sent.
- R6: If SDA reads low during a data bit in which the engine released it, bus_collision is set, both lines are released, busy drops and buf_full clears.
- R7: A collision during a Start condition aborts it and clears all cmd_pending bits (bit 0 Start, bit 1 Repeated Start, bit 2 Stop, bit 3 Acknowledge).
- R8: A collision during a Repeated Start, or during an Acknowledge sent with ack_val = 1 (released), aborts that condition, releases both lines and clears cmd_pending.
- R9: After a collision, the buffer can be written again, and the next transfer sends the new byte starting from its most significant bit.
- R10: A Stop seen on the bus sets irq, including a Stop that another master makes after a collision.
- R11: bus_collision stays set until coll_clr is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable; low clears status and aborts |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| wr_valid | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DW | Byte to transmit |
| buf_full | output | 1 | Transmit buffer holds an unsent byte |
| cmd_start | input | 1 | Request a Start condition |
| cmd_rstart | input | 1 | Request a Repeated Start condition |
| cmd_stop | input | 1 | Request a Stop condition |
| cmd_ack | input | 1 | Request an Acknowledge bit |
| ack_val | input | 1 | Level for the Acknowledge bit, latched with cmd_ack |
| cmd_pending | output | 4 | Pending commands: Start, Repeated Start, Stop, Acknowledge (bit 0 to 3) |
| busy | output | 1 | Engine is not idle |
| rx_nack | output | 1 | Acknowledge level sampled on the last ninth clock |
| start_seen | output | 1 | Last condition seen on the bus was a Start |
| stop_seen | output | 1 | Last condition seen on the bus was a Stop |
| bus_collision | output | 1 | Sticky arbitration-loss flag |
| coll_clr | input | 1 | Clears bus_collision |
| irq | output | 1 | Sticky event flag (operation done or Stop seen) |
| irq_clr | input | 1 | Clears irq |

## Verification
A line edge reaches start_seen or stop_seen three clocks later: two synchronizer stages, then the status register. The bench therefore samples those bits a fixed ten clocks after it moves a line. A collision is flagged at the tick that closes the quarter holding the check, no more than one bit time after the line is pulled. Byte completion takes nine bits of four quarters each. The bench waits for these outputs with bounded polling loops that sample on the falling clock edge and then checks their values. A released start in the busy-bus case must reach busy within four clocks, so that check is placed ten clocks after the line is released.

// File: rtl/i2c_arb_pkg.sv
// Shared types for the multi-master I2C transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_arb_pkg;

    // Engine phase; each active phase spans four quarter periods
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RSTART,
        ST_STOP,
        ST_ACK,
        ST_TX,
        ST_HOLD
    } phase_e;

    // Command slot positions inside the pending vector
    localparam int CMD_START  = 0;
    localparam int CMD_RSTART = 1;
    localparam int CMD_STOP   = 2;
    localparam int CMD_ACK    = 3;
    localparam int NCMD       = 4;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL/SDA, detects Start/Stop conditions and keeps the
// start-seen / stop-seen status that defines when the bus is free.
// Assumes: SYNC >= 2; line inputs are asynchronous to clk.
module i2c_line_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic s_seen,
    output logic p_seen,
    output logic bus_free
);

    logic [SYNC-1:0] scl_ff, sda_ff;
    logic            scl_prev, sda_prev;

    // Synchronizer chains, reset to the idle-high level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[SYNC-2:0], scl_raw};
            sda_ff <= {sda_ff[SYNC-2:0], sda_raw};
        end
    end

    assign scl_s = scl_ff[SYNC-1];
    assign sda_s = sda_ff[SYNC-1];

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign start_det = scl_prev && scl_s && sda_prev && !sda_s;
    assign stop_det  = scl_prev && scl_s && !sda_prev && sda_s;

    // Start/Stop status bits, cleared on reset or disable
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            s_seen <= 1'b0;
            p_seen <= 1'b0;
        end else if (start_det) begin
            s_seen <= 1'b1;
            p_seen <= 1'b0;
        end else if (stop_det) begin
            s_seen <= 1'b0;
            p_seen <= 1'b1;
        end
    end

    assign bus_free = p_seen || !s_seen;

    AST_SP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_seen && p_seen)); // R2

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!s_seen && !p_seen)); // R2

endmodule

// File: rtl/i2c_quarter_tick.sv
// Produces one tick per DIV clocks while the engine is in an active
// phase; the count restarts whenever the engine leaves active phases.
// Assumes: DIV >= 4 so a quarter outlasts the synchronizer latency.
module i2c_quarter_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Quarter-period counter, held at zero while not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = run && (cnt == LAST);

    AST_TICK_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4

endmodule

// File: rtl/i2c_arb_master.sv
// Multi-master I2C transmit engine. Issues Start, Repeated Start, Stop
// and Acknowledge conditions and shifts bytes out MSB first. Checks SDA
// against the released level while SCL is high and, on a mismatch,
// drops the operation, releases both lines and flags a collision.
// Assumes: no clock stretching by other devices; DIV >= 4.
module i2c_arb_master
    import i2c_arb_pkg::*;
#(
    parameter int DIV  = 8,
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          buf_full,
    input  logic          cmd_start,
    input  logic          cmd_rstart,
    input  logic          cmd_stop,
    input  logic          cmd_ack,
    input  logic          ack_val,
    output logic [3:0]    cmd_pending,
    output logic          busy,
    output logic          rx_nack,
    output logic          start_seen,
    output logic          stop_seen,
    output logic          bus_collision,
    input  logic          coll_clr,
    output logic          irq,
    input  logic          irq_clr
);

    localparam int BW = $clog2(DW + 1);
    localparam logic [BW-1:0] ACK_SLOT = BW'(DW);

    phase_e          st;
    logic [1:0]      qtr;
    logic [BW-1:0]   bitcnt;
    logic [DW-1:0]   shreg, txbuf;
    logic [NCMD-1:0] pend, pend_set;
    logic            buf_full_q, ack_latch, ack_bit, hold_sda;
    logic            coll_q, irq_q, nack_q;
    logic            scl_s, sda_s, start_det, stop_det, s_seen, p_seen, bus_free;
    logic            run, tick, scl_rel, sda_rel, chk, collide, last_bit, op_done;

    i2c_line_sync #(.SYNC(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_det(start_det),
        .stop_det (stop_det),
        .s_seen   (s_seen),
        .p_seen   (p_seen),
        .bus_free (bus_free)
    );

    assign run = (st != ST_IDLE) && (st != ST_HOLD);

    i2c_quarter_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    assign last_bit = (bitcnt == ACK_SLOT);

    // Line levels and arbitration check point for each phase and quarter
    always_comb begin
        scl_rel = 1'b1;
        sda_rel = 1'b1;
        chk     = 1'b0;
        case (st)
            ST_IDLE: begin
                scl_rel = 1'b1;
                sda_rel = 1'b1;
            end
            ST_HOLD: begin
                scl_rel = 1'b0;
                sda_rel = hold_sda;
            end
            ST_START: begin
                scl_rel = (qtr != 2'd3);
                sda_rel = (qtr == 2'd0);
                chk     = (qtr == 2'd0);
            end
            ST_RSTART: begin
                scl_rel = (qtr == 2'd1) || (qtr == 2'd2);
                sda_rel = (qtr <= 2'd1);
                chk     = (qtr == 2'd1);
            end
            ST_STOP: begin
                scl_rel = (qtr != 2'd0);
                sda_rel = (qtr >= 2'd2);
                chk     = (qtr == 2'd3);
            end
            ST_ACK: begin
                scl_rel = (qtr == 2'd1) || (qtr == 2'd2);
                sda_rel = ack_bit;
                chk     = (qtr == 2'd2);
            end
            ST_TX: begin
                scl_rel = (qtr == 2'd1) || (qtr == 2'd2);
                sda_rel = last_bit ? 1'b1 : shreg[DW-1];
                chk     = (qtr == 2'd2) && !last_bit;
            end
            default: begin
                scl_rel = 1'b1;
                sda_rel = 1'b1;
            end
        endcase
    end

    assign collide  = tick && chk && sda_rel && scl_s && !sda_s;
    assign op_done  = tick && !collide && (qtr == 2'd3) && (st != ST_TX || last_bit);
    assign pend_set = enable ? {cmd_ack, cmd_stop, cmd_rstart, cmd_start} : '0;

    // Phase sequencer, pending commands and transmit buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            qtr        <= 2'd0;
            bitcnt     <= '0;
            shreg      <= '0;
            txbuf      <= '0;
            pend       <= '0;
            buf_full_q <= 1'b0;
            ack_latch  <= 1'b0;
            ack_bit    <= 1'b1;
            hold_sda   <= 1'b1;
            nack_q     <= 1'b0;
        end else if (!enable) begin
            st         <= ST_IDLE;
            qtr        <= 2'd0;
            pend       <= '0;
            buf_full_q <= 1'b0;
        end else begin
            pend <= pend | pend_set;
            if (cmd_ack) begin
                ack_latch <= ack_val;
            end
            if (wr_valid && !buf_full_q) begin
                txbuf      <= wr_data;
                buf_full_q <= 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (pend[CMD_START] && bus_free) begin
                        st  <= ST_START;
                        qtr <= 2'd0;
                    end
                end
                ST_HOLD: begin
                    qtr <= 2'd0;
                    if (pend[CMD_RSTART]) begin
                        st <= ST_RSTART;
                    end else if (pend[CMD_STOP]) begin
                        st <= ST_STOP;
                    end else if (pend[CMD_ACK]) begin
                        st      <= ST_ACK;
                        ack_bit <= ack_latch;
                    end else if (buf_full_q) begin
                        st     <= ST_TX;
                        shreg  <= txbuf;
                        bitcnt <= '0;
                    end
                end
                default: begin
                    if (collide) begin
                        st         <= ST_IDLE;
                        qtr        <= 2'd0;
                        pend       <= '0;
                        buf_full_q <= 1'b0;
                    end else if (tick) begin
                        if (st == ST_TX && last_bit && qtr == 2'd2) begin
                            nack_q <= sda_s;
                        end
                        if (qtr != 2'd3) begin
                            qtr <= qtr + 2'd1;
                        end else begin
                            qtr <= 2'd0;
                            case (st)
                                ST_START: begin
                                    pend[CMD_START] <= 1'b0;
                                    st              <= ST_HOLD;
                                    hold_sda        <= 1'b0;
                                end
                                ST_RSTART: begin
                                    pend[CMD_RSTART] <= 1'b0;
                                    st               <= ST_HOLD;
                                    hold_sda         <= 1'b0;
                                end
                                ST_STOP: begin
                                    pend[CMD_STOP] <= 1'b0;
                                    st             <= ST_IDLE;
                                end
                                ST_ACK: begin
                                    pend[CMD_ACK] <= 1'b0;
                                    st            <= ST_HOLD;
                                    hold_sda      <= ack_bit;
                                end
                                default: begin
                                    if (last_bit) begin
                                        buf_full_q <= 1'b0;
                                        st         <= ST_HOLD;
                                        hold_sda   <= 1'b1;
                                    end else begin
                                        bitcnt <= bitcnt + BW'(1);
                                        shreg  <= {shreg[DW-2:0], 1'b0};
                                    end
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // Sticky collision and event flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (coll_clr) begin
                coll_q <= 1'b0;
            end
            if (collide && enable) begin
                coll_q <= 1'b1;
            end
            if (irq_clr) begin
                irq_q <= 1'b0;
            end
            if (enable && (stop_det || op_done)) begin
                irq_q <= 1'b1;
            end
        end
    end

    assign scl_oe        = !scl_rel;
    assign sda_oe        = !sda_rel;
    assign buf_full      = buf_full_q;
    assign cmd_pending   = pend;
    assign busy          = (st != ST_IDLE);
    assign rx_nack       = nack_q;
    assign start_seen    = s_seen;
    assign stop_seen     = p_seen;
    assign bus_collision = coll_q;
    assign irq           = irq_q;

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START && $past(st) == ST_IDLE) |-> $past(bus_free)); // R3

    AST_TX_SDA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && $past(st) == ST_TX && scl_rel && $past(scl_rel)) |-> $stable(sda_rel)); // R4

    AST_FULL_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full_q && wr_valid) |=> $stable(txbuf)); // R5

    AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_q) |-> (scl_rel && sda_rel && !buf_full_q && st == ST_IDLE)); // R6

    AST_COLL_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_q) |-> (pend == '0)); // R7

    AST_TX_FROM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && $past(st) == ST_HOLD) |-> (bitcnt == '0)); // R9

    AST_STOP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && enable) |=> irq_q); // R10

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_q && !coll_clr) |=> coll_q); // R11

endmodule

// File: tb/i2c_arb_master_test.sv
module i2c_arb_master_test;

    localparam int DIV = 8;
    localparam int DW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic cmd_start = 1'b0, cmd_rstart = 1'b0, cmd_stop = 1'b0, cmd_ack = 1'b0;
    logic ack_val = 1'b0, coll_clr = 1'b0, irq_clr = 1'b0;
    logic scl_oe, sda_oe, buf_full, busy, rx_nack, start_seen, stop_seen;
    logic bus_collision, irq;
    logic [3:0] cmd_pending;
    logic scl_i, sda_i;

    // Other-device line drivers
    logic ext_sda_low = 1'b0;
    logic ack_arm = 1'b0;
    logic inj_arm = 1'b0;
    int   fall_base = 0;
    int   ack_at = 9;
    int   inj_at = 4;
    int   fall_cnt = 0;
    logic scl_prev = 1'b1;
    logic [31:0] hist = '0;
    logic ack_low, inj_low;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign ack_low = ack_arm && ((fall_cnt - fall_base) == ack_at);
    assign inj_low = inj_arm && ((fall_cnt - fall_base) >= inj_at);
    assign scl_i   = !scl_oe;
    assign sda_i   = !(sda_oe || ext_sda_low || ack_low || inj_low);

    i2c_arb_master #(.DIV(DIV), .DW(DW), .SYNC(2)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .wr_valid(wr_valid), .wr_data(wr_data), .buf_full(buf_full),
        .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
        .cmd_ack(cmd_ack), .ack_val(ack_val), .cmd_pending(cmd_pending),
        .busy(busy), .rx_nack(rx_nack), .start_seen(start_seen),
        .stop_seen(stop_seen), .bus_collision(bus_collision),
        .coll_clr(coll_clr), .irq(irq), .irq_clr(irq_clr)
    );

    // Bus observer: counts SCL falls and records SDA on every SCL rise
    always @(negedge clk) begin
        if (scl_prev && !scl_i) fall_cnt <= fall_cnt + 1;
        if (!scl_prev && scl_i) hist <= {hist[30:0], sda_i};
        scl_prev <= scl_i;
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // kind: 0 command pulse start,1 rstart,2 stop,3 ack,4 coll_clr,5 irq_clr
    task automatic pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: cmd_start  = 1'b1;
            1: cmd_rstart = 1'b1;
            2: cmd_stop   = 1'b1;
            3: cmd_ack    = 1'b1;
            4: coll_clr   = 1'b1;
            default: irq_clr = 1'b1;
        endcase
        @(negedge clk);
        {cmd_start, cmd_rstart, cmd_stop, cmd_ack, coll_clr, irq_clr} = '0;
    endtask

    task automatic write_byte(input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    function automatic logic cond(input int kind);
        case (kind)
            0: return !buf_full;
            1: return cmd_pending == 4'b0;
            2: return !busy;
            3: return bus_collision;
            default: return busy;
        endcase
    endfunction

    task automatic wait_for(input int kind, input int max);
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (cond(kind)) break;
        end
    endtask

    // Full write-start-byte-stop transfer with computed expectations
    task automatic transfer(input logic [DW-1:0] d, input logic ack, input string tag);
        write_byte(d);
        fall_base = fall_cnt;
        ack_at    = 9;
        ack_arm   = ack;
        pulse(0);
        wait_for(0, 2000);
        cycles(2);
        check_eq({tag, " byte MSB first"}, {24'd0, hist[8:1]}, {24'd0, d});
        check_eq({tag, " ninth-clock ack"}, {31'd0, rx_nack}, {31'd0, !ack});
        ack_arm = 1'b0;
        pulse(2);
        wait_for(2, 2000);
        cycles(10);
    endtask

    initial begin
        int seed;
        logic [DW-1:0] d;
        seed = $urandom(32'd20240607);
        cycles(5);
        rst_n  = 1'b1;
        enable = 1'b1;
        cycles(2);
        // R1: reset state
        check_eq("R1 reset outputs",
            {22'd0, scl_oe, sda_oe, bus_collision, irq, buf_full, busy, start_seen, stop_seen, cmd_pending == 4'b0 ? 2'b00 : 2'b11},
            32'd0);

        // R5: second write while full is ignored; R4/R2 on first transfer
        write_byte(8'h3C);
        check_eq("R5 buf_full after write", {31'd0, buf_full}, 32'd1);
        write_byte(8'hC3);
        fall_base = fall_cnt;
        pulse(0);
        wait_for(0, 2000);
        cycles(2);
        check_eq("R5 buffered byte kept", {24'd0, hist[8:1]}, 32'h3C);
        check_eq("R2 own start seen", {30'd0, start_seen, stop_seen}, 32'd2);
        check_eq("R4 irq after byte", {31'd0, irq}, 32'd1);
        pulse(5);
        pulse(2);
        wait_for(2, 2000);
        cycles(10);
        check_eq("R2 own stop seen", {30'd0, start_seen, stop_seen}, 32'd1);
        check_eq("R10 irq on stop", {31'd0, irq}, 32'd1);
        check_eq("R2 lines released after stop", {30'd0, scl_oe, sda_oe}, 32'd0);

        // R4: random bytes and random acknowledge
        for (int k = 0; k < 6; k++) begin
            d = DW'($urandom);
            transfer(d, 1'($urandom % 2), "R4");
        end
        // R4 directed corners
        transfer(8'h00, 1'b1, "R4");
        transfer(8'hFF, 1'b0, "R4");

        // R3: another master holds the bus
        @(negedge clk) ext_sda_low = 1'b1;
        cycles(10);
        check_eq("R2 foreign start", {30'd0, start_seen, stop_seen}, 32'd2);
        pulse(0);
        cycles(100);
        check_eq("R3 start held pending", {27'd0, busy, sda_oe, cmd_pending}, 32'h01);
        @(negedge clk) ext_sda_low = 1'b0;
        cycles(10);
        check_eq("R3 start after foreign stop", {31'd0, busy}, 32'd1);
        wait_for(1, 2000);
        pulse(2);
        wait_for(2, 2000);
        cycles(10);

        // R2: disable clears status
        @(negedge clk) enable = 1'b0;
        cycles(2);
        check_eq("R2 disable clears S/P", {30'd0, start_seen, stop_seen}, 32'd0);
        @(negedge clk) enable = 1'b1;
        cycles(2);

        // R6: collision on the fourth data bit
        write_byte(8'hFF);
        fall_base = fall_cnt;
        inj_at    = 4;
        inj_arm   = 1'b1;
        pulse(0);
        wait_for(3, 2000);
        cycles(2);
        check_eq("R6 data collision abort",
            {27'd0, bus_collision, scl_oe, sda_oe, busy, buf_full}, 32'h10);
        pulse(5);
        cycles(50);
        check_eq("R11 collision flag sticky", {31'd0, bus_collision}, 32'd1);
        check_eq("R10 irq clear before stop", {31'd0, irq}, 32'd0);
        @(negedge clk) inj_arm = 1'b0;
        cycles(10);
        check_eq("R10 irq on foreign stop", {30'd0, irq, stop_seen}, 32'd3);
        pulse(4);
        check_eq("R11 coll_clr clears", {31'd0, bus_collision}, 32'd0);

        // R9: retry sends new byte from its MSB
        transfer(8'hA5, 1'b0, "R9");

        // R7: collision during Start
        pulse(0);
        wait_for(4, 200);
        ext_sda_low = 1'b1;
        wait_for(3, 200);
        cycles(1);
        check_eq("R7 start collision", {26'd0, bus_collision, busy, cmd_pending}, 32'h20);
        @(negedge clk) ext_sda_low = 1'b0;
        cycles(10);
        pulse(4);

        // R8: collision during Acknowledge with released level
        pulse(0);
        wait_for(1, 2000);
        @(negedge clk) ext_sda_low = 1'b1;
        ack_val = 1'b1;
        pulse(3);
        wait_for(3, 500);
        cycles(1);
        check_eq("R8 ack collision",
            {25'd0, bus_collision, scl_oe, sda_oe, cmd_pending}, 32'h40);
        @(negedge clk) ext_sda_low = 1'b0;
        cycles(10);
        pulse(4);

        // R8: collision during Repeated Start
        pulse(0);
        wait_for(1, 2000);
        @(negedge clk) ext_sda_low = 1'b1;
        pulse(1);
        wait_for(3, 500);
        cycles(1);
        check_eq("R8 repeated start collision",
            {25'd0, bus_collision, scl_oe, sda_oe, cmd_pending}, 32'h40);
        @(negedge clk) ext_sda_low = 1'b0;
        cycles(10);
        pulse(4);
        check_eq("R10 stop after repeated start collision", {31'd0, stop_seen}, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

endmodule